// File: doc/BRIEF.md
# Early Instruction Termination Mask

A microinstruction that tests one bit of the instruction register can also finish the instruction early. It does so when that bit and every lower bit of the register are clear. A 4-bit bit-test code selects which bit is tested. The code is decoded into a 10-bit thermometer mask, so the tested bit and all bits below it are enabled. The mask is ANDed with the low ten instruction-register bits. If any enabled bit is set, the active-low end request from the microcode is held off. If every enabled bit is clear, the end request goes through, and the instruction stops instead of stepping through microcycles that have nothing left to do.

The mask decoder and the end gate are purely combinational. A small registered micro-sequencer sits around them so the effect can be observed over cycles:
- Each cycle, the micro-PC either advances by one or returns to zero.
- It returns to zero in the cycle after the gated end goes low.

The sequencer has three states:
- `SQ_IDLE`: after reset.
- `SQ_RUN`: reached on any cycle whose gated end is high.
- `SQ_RESTART`: reached on any cycle whose gated end is low.

From every state, the next state depends only on the gated end. Each transition therefore reaches `SQ_RUN` or `SQ_RESTART`, and no transition returns to `SQ_IDLE`.

Top module: `early_end_seq`

## Requirements
- R1: While reset is asserted and at release, `upc` is 0 and `restart` is 0.
- R2: When `end_n_in` is 1, `end_n_out` is 1 whatever the code and IR.
- R3: When `end_n_in` is 0 and `if_code` is 0 (no bit test), `end_n_out` is 0.
- R4: For `if_code` = k with 1 ≤ k ≤ 10 (test of IR bit k-1), the mask has ones in bits 0..k-1. With `end_n_in` 0, `end_n_out` is 1 exactly when some IR bit among bits 0..k-1 is 1.
- R5: IR bits at positions k and above have no effect on `end_n_out` for `if_code` = k.
- R6: Codes 11 to 15 give an all-zero mask. With `end_n_in` 0, `end_n_out` is then 0 for any IR.
- R7: In the cycle after a clock edge at which `end_n_out` was 0, `upc` is 0 and `restart` is 1 (state `SQ_RESTART`).
- R8: In the cycle after a clock edge at which `end_n_out` was 1, `upc` is its previous value plus one, modulo 2^UPC_W, and `restart` is 0 (state `SQ_RUN`).
- R9: For `if_code` = 10 (test of IR bit 9), with `end_n_in` 0, `end_n_out` is 0 only when all ten IR bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| end_n_in | input | 1 | Active-low end request from the microinstruction |
| if_code | input | 4 | Bit-test code: 0 = none, k = test IR bit k-1 |
| ir | input | 10 | Low instruction-register bits |
| end_n_out | output | 1 | Gated active-low end |
| upc | output | UPC_W (6) | Micro-PC |
| restart | output | 1 | High in the cycle after an end |

## Verification
Directed patterns place a single set IR bit on each side of the mask boundary for every valid code. A bit just inside the boundary must hold off the end, and a bit just outside must not, which separates an off-by-one mask from a correct one. Unused codes paired with an all-ones IR separate a zeroed mask from a saturated one. The extremes, code 10 with an empty IR and with only bit 9 set, confirm the top mask bit. Random codes, IR values and end requests then exercise the sequencer's advance and return-to-zero paths in long mixed runs, with the micro-PC wrapping.

// File: rtl/eet_pkg.sv
package eet_pkg;

    // Micro-sequencer states
    typedef enum logic [1:0] {
        SQ_IDLE    = 2'd0,
        SQ_RUN     = 2'd1,
        SQ_RESTART = 2'd2
    } sq_state_e;

endpackage

// File: rtl/eet_mask_dec.sv
module eet_mask_dec #(
    parameter int IR_W   = 10,
    parameter int CODE_W = 4
) (
    input  logic [CODE_W-1:0] code,
    output logic [IR_W-1:0]   mask
);

    localparam int CODE_MAX = IR_W;

    // Bit i is enabled when the tested bit is at or above i.
    // Codes past CODE_MAX are unused and enable nothing.
    for (genvar i = 0; i < IR_W; i++) begin : g_bit
        always_comb begin
            mask[i] = (int'(code) >= i + 1) && (int'(code) <= CODE_MAX);
        end
    end

endmodule

// File: rtl/eet_end_gate.sv
module eet_end_gate #(
    parameter int IR_W = 10
) (
    input  logic            end_n_in,
    input  logic [IR_W-1:0] mask,
    input  logic [IR_W-1:0] ir,
    output logic            end_n_out
);

    logic hit;

    always_comb begin
        hit       = |(mask & ir);
        end_n_out = end_n_in | hit;
    end

endmodule

// File: rtl/eet_useq.sv
module eet_useq
    import eet_pkg::*;
#(
    parameter int UPC_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             end_n,
    output logic [UPC_W-1:0] upc,
    output logic             restart
);

    sq_state_e        state_q, state_d;
    logic [UPC_W-1:0] upc_q, upc_d;

    // Next-state and next-PC logic
    always_comb begin
        state_d = state_q;
        upc_d   = upc_q;
        unique case (state_q)
            SQ_IDLE, SQ_RUN, SQ_RESTART: begin
                if (!end_n) begin
                    state_d = SQ_RESTART;
                    upc_d   = '0;
                end else begin
                    state_d = SQ_RUN;
                    upc_d   = upc_q + 1'b1;
                end
            end
            default: begin
                state_d = SQ_IDLE;
                upc_d   = '0;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SQ_IDLE;
            upc_q   <= '0;
        end else begin
            state_q <= state_d;
            upc_q   <= upc_d;
        end
    end

    // Outputs
    always_comb begin
        upc = upc_q;
        unique case (state_q)
            SQ_RESTART: restart = 1'b1;
            default:    restart = 1'b0;
        endcase
    end

endmodule

// File: rtl/early_end_seq.sv
module early_end_seq #(
    parameter int IR_W   = 10,
    parameter int CODE_W = 4,
    parameter int UPC_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              end_n_in,
    input  logic [CODE_W-1:0] if_code,
    input  logic [IR_W-1:0]   ir,
    output logic              end_n_out,
    output logic [UPC_W-1:0]  upc,
    output logic              restart
);

    logic [IR_W-1:0] mask;

    eet_mask_dec #(.IR_W(IR_W), .CODE_W(CODE_W)) u_dec (
        .code (if_code),
        .mask (mask)
    );

    eet_end_gate #(.IR_W(IR_W)) u_gate (
        .end_n_in  (end_n_in),
        .mask      (mask),
        .ir        (ir),
        .end_n_out (end_n_out)
    );

    eet_useq #(.UPC_W(UPC_W)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .end_n   (end_n_out),
        .upc     (upc),
        .restart (restart)
    );

endmodule

// File: rtl/early_end_seq_chk.sv
module early_end_seq_chk #(
    parameter int IR_W   = 10,
    parameter int CODE_W = 4,
    parameter int UPC_W  = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              end_n_in,
    input logic [CODE_W-1:0] if_code,
    input logic [IR_W-1:0]   ir,
    input logic              end_n_out,
    input logic [UPC_W-1:0]  upc,
    input logic              restart
);

    // R2
    r2_end_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        end_n_in |-> end_n_out);

    // R3
    r3_no_test_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!end_n_in && if_code == '0) |-> !end_n_out);

    // R6
    r6_unused_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!end_n_in && int'(if_code) > IR_W) |-> !end_n_out);

    // R9
    r9_full_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!end_n_in && int'(if_code) == IR_W) |-> (end_n_out == (|ir)));

    // R7
    r7_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !end_n_out |=> (upc == '0 && restart));

    // R8
    r8_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        end_n_out |=> (upc == $past(upc) + 1'b1 && !restart));

endmodule

bind early_end_seq early_end_seq_chk #(
    .IR_W(IR_W), .CODE_W(CODE_W), .UPC_W(UPC_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .end_n_in(end_n_in), .if_code(if_code),
    .ir(ir), .end_n_out(end_n_out), .upc(upc), .restart(restart)
);

// File: tb/early_end_seq_bench.sv
module early_end_seq_bench;

    localparam int IR_W  = 10;
    localparam int UPC_W = 6;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             end_n_in = 1'b1;
    logic [3:0]       if_code = '0;
    logic [IR_W-1:0]  ir = '0;
    logic             end_n_out;
    logic [UPC_W-1:0] upc;
    logic             restart;

    int n_run = 0;
    int n_fail = 0;
    logic [UPC_W-1:0] exp_upc = '0;
    logic             exp_rst = 1'b0;

    always #2 clk = ~clk;

    early_end_seq u_early_end_seq (
        .clk(clk), .rst_n(rst_n), .end_n_in(end_n_in), .if_code(if_code),
        .ir(ir), .end_n_out(end_n_out), .upc(upc), .restart(restart)
    );

    function automatic logic model_end(logic e, logic [3:0] c, logic [IR_W-1:0] v);
        logic [IR_W-1:0] m;
        if (e) return 1'b1;
        if (c == 0 || c > IR_W) return 1'b0;
        m = IR_W'((11'd1 << c) - 11'd1);
        return |(v & m);
    endfunction

    task automatic check(string req, int act, int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Called at a falling edge: drive, check comb, then check registers next fall.
    task automatic step(logic e, logic [3:0] c, logic [IR_W-1:0] v, string req);
        logic want;
        end_n_in = e; if_code = c; ir = v;
        #1;
        want = model_end(e, c, v);
        check(req, end_n_out, want);
        if (!want) begin
            exp_upc = '0; exp_rst = 1'b1;
        end else begin
            exp_upc = exp_upc + 1'b1; exp_rst = 1'b0;
        end
        @(negedge clk);
        check(want ? "R8" : "R7", upc, exp_upc);
        check(want ? "R8" : "R7", restart, exp_rst);
    endtask

    initial begin
        #400000;
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        check("R1", upc, 0);
        check("R1", restart, 0);
        rst_n = 1'b1;
        #1;
        check("R1", upc, 0);
        @(negedge clk);
        exp_upc = 1; exp_rst = 0;
        check("R8", upc, exp_upc);

        // R2 end not requested passes through high
        step(1'b1, 4'd0, '0, "R2");
        step(1'b1, 4'd5, '0, "R2");
        // R3 no test
        step(1'b0, 4'd0, '1, "R3");
        // R4 and R5 at each boundary
        for (int k = 1; k <= IR_W; k++) begin
            step(1'b0, 4'(k), IR_W'(1) << (k - 1), "R4");
            if (k < IR_W) step(1'b0, 4'(k), IR_W'(1) << k, "R5");
            if (k < IR_W) step(1'b0, 4'(k), ~((IR_W'(1) << k) - 1'b1), "R5");
        end
        // R6 unused codes
        for (int c = IR_W + 1; c < 16; c++) step(1'b0, 4'(c), '1, "R6");
        // R9 top code
        step(1'b0, 4'd10, '0, "R9");
        step(1'b0, 4'd10, 10'h200, "R9");
        // Long run without end to wrap micro-PC
        for (int i = 0; i < 70; i++) step(1'b1, 4'd0, '0, "R8");
        // Random mix
        for (int i = 0; i < 2000; i++) begin
            step(($urandom % 4) == 0, 4'($urandom % 16),
                 IR_W'(($urandom % 3 == 0) ? 0 : ($urandom >> ($urandom % 10))),
                 "R4");
        end
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule